// File: doc/BRIEF.md
# Check-Byte Alias Read Multiplexer

This block sits in front of a RAM whose entries hold one 64-bit data word and one 8-bit check byte each. It decodes two address windows onto that RAM. A read in the data window returns the stored word and its check byte unchanged. A read in the check window returns only the check byte of the addressed word. That byte is copied into every byte lane of the 64-bit data bus and is also driven on the in-band check bus. Software can therefore inspect stored check codes through ordinary loads.

The value returned from the check window has no check code of its own. A downstream checker that treats the data/check pair as a normal protected word may report no error, a single-bit error or a double-bit error. The block leaves that interpretation to the consumer.

Reads use a one-request, one-response port. Every request produces exactly one response, one cycle later, whichever window it hits. Addresses outside both windows return a decode-error response with zero data and do not touch the RAM.

Top module: `ecc_alias_rd`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `rsp_valid` is 0, even if `req_valid` is high.
- R2: A read at byte address A inside the data window (base 0x0800_0000, size DEPTH×8 bytes) returns, one cycle later, the RAM word and check byte at index (A−0x0800_0000)>>3 on `rsp_data` and `rsp_ecc`.
- R3: The check window starts at 0x0840_0000 and has the same size as the data window. The word index there is (A−0x0840_0000)>>3. Address bits [2:0] are ignored in both windows, and no address falls in both windows.
- R4: On a check-window read, `rsp_data` equals the addressed check byte repeated in all eight byte lanes.
- R5: On a check-window read, `rsp_ecc` equals that same check byte.
- R6: An address in neither window (including the first byte past either window's end) gives `rsp_derr`=1 with `rsp_data`=0 and `rsp_ecc`=0, and `ram_rd_en` stays 0 for that request.
- R7: Every accepted request yields `rsp_valid` high for exactly one cycle, one cycle after the request, for all three outcomes. Back-to-back requests yield back-to-back responses, and idle cycles yield none.
- R8: `rsp_derr` is 0 on every read that hits either window.
- R9: For an in-window request, `ram_rd_en` is 1 in the request cycle and `ram_rd_idx` carries the word index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request strobe, one request per cycle |
| req_addr | input | 32 | Byte address of the read |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_data | output | 64 | Read data |
| rsp_ecc | output | 8 | In-band check byte |
| rsp_derr | output | 1 | Decode error, address in neither window |
| ram_rd_en | output | 1 | RAM read enable |
| ram_rd_idx | output | 10 | RAM word index |
| ram_rd_data | input | 64 | RAM data, valid one cycle after the enable |
| ram_rd_ecc | input | 8 | RAM check byte, valid one cycle after the enable |

## Verification
The bench's RAM model derives each word and check byte from its index, so a wrong index, lane or window shows up as a mismatched value. The vectors include reads at the base, in the middle and at the last word of each window, the first byte past each window, an address just below the data window, and address zero. Unaligned offsets show that bits [2:0] are dropped. Requests of all three kinds are sent back to back, so a response carrying the previous request's kind is caught. A final idle gap and a reset taken during a request show that no response appears without a request.

// File: rtl/ecc_alias_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the check-byte alias read path.
// Assumes: nothing beyond IEEE 1800-2017.
package ecc_alias_pkg;

    // Which window a request address fell into.
    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_DATA  = 2'd1,
        WIN_CHECK = 2'd2
    } win_e;

endpackage

// File: rtl/ecc_alias_decode.sv
`timescale 1ns/1ps
// Module: ecc_alias_decode
// Classifies a byte address into the data window, the check window or neither.
// Returns the RAM word index that the address selects.
// Assumes: both windows are the same size, do not overlap, and each word
// spans WORD_BYTES bytes whose low address bits are ignored.
module ecc_alias_decode
    import ecc_alias_pkg::*;
#(
    parameter int                  ADDR_W     = 32,
    parameter int                  IDX_W      = 10,
    parameter int                  WORD_BYTES = 8,
    parameter logic [ADDR_W-1:0]   DATA_BASE  = 32'h0800_0000,
    parameter logic [ADDR_W-1:0]   CHECK_BASE = 32'h0840_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [IDX_W-1:0]  idx
);
    localparam int                BYTE_SH  = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'((64'd1 << IDX_W) * WORD_BYTES);

    logic [ADDR_W-1:0] off_data;
    logic [ADDR_W-1:0] off_check;
    logic              hit_data;
    logic              hit_check;

    // Window hit tests by offset from each base.
    always_comb begin
        off_data  = addr - DATA_BASE;
        off_check = addr - CHECK_BASE;
        hit_data  = (addr >= DATA_BASE)  && (off_data  < WIN_SIZE);
        hit_check = (addr >= CHECK_BASE) && (off_check < WIN_SIZE);
    end

    // Select the window kind and the word index it implies.
    always_comb begin
        win = WIN_NONE;
        idx = '0;
        if (hit_data) begin
            win = WIN_DATA;
            idx = IDX_W'(off_data >> BYTE_SH);
        end else if (hit_check) begin
            win = WIN_CHECK;
            idx = IDX_W'(off_check >> BYTE_SH);
        end
    end

    // R3: the windows must never overlap.
    always_comb begin
        p_single_window_r3: assert ($onehot0({hit_data, hit_check}))
            else $error("address hits both windows");
    end

endmodule

// File: rtl/ecc_alias_resp.sv
`timescale 1ns/1ps
// Module: ecc_alias_resp
// Forms the response from the registered window kind and the RAM output.
// Check-window reads copy the check byte into every lane of the data bus.
// Assumes: DATA_W is a whole multiple of ECC_W, and the RAM output is valid
// in the cycle after the read enable.
module ecc_alias_resp
    import ecc_alias_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_q,
    input  win_e              win_q,
    input  logic [DATA_W-1:0] ram_data,
    input  logic [ECC_W-1:0]  ram_ecc,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ECC_W-1:0]  rsp_ecc,
    output logic              rsp_derr
);
    localparam int LANES = DATA_W / ECC_W;

    logic [DATA_W-1:0] repl;

    // Copy the check byte into each lane of the data bus.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign repl[g*ECC_W +: ECC_W] = ram_ecc;
    end

    // Steer the RAM output or the copied byte by window kind.
    always_comb begin
        rsp_valid = valid_q;
        rsp_data  = '0;
        rsp_ecc   = '0;
        rsp_derr  = 1'b0;
        if (valid_q) begin
            unique case (win_q)
                WIN_DATA: begin
                    rsp_data = ram_data;
                    rsp_ecc  = ram_ecc;
                end
                WIN_CHECK: begin
                    rsp_data = repl;
                    rsp_ecc  = ram_ecc;
                end
                default: rsp_derr = 1'b1;
            endcase
        end
    end

    // R4, R5: each data lane of a check-window response matches the check bus.
    p_alias_repl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && win_q == WIN_CHECK) |-> rsp_data == {LANES{rsp_ecc}})
        else $error("check-window lanes differ from check bus");

    // R6: a decode error carries no data.
    p_derr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_derr |-> (rsp_data == '0 && rsp_ecc == '0 && rsp_valid))
        else $error("decode error with nonzero data");

endmodule

// File: rtl/ecc_alias_rd.sv
`timescale 1ns/1ps
// Module: ecc_alias_rd (top)
// Read mux with a data window and a check-byte alias window over a RAM.
// Each request gets one response a cycle later, whatever the address.
// Assumes: the RAM returns data and check byte one cycle after ram_rd_en,
// and at most one request is presented per cycle.
module ecc_alias_rd
    import ecc_alias_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 64,
    parameter int                ECC_W      = 8,
    parameter int                IDX_W      = 10,
    parameter logic [ADDR_W-1:0] DATA_BASE  = 32'h0800_0000,
    parameter logic [ADDR_W-1:0] CHECK_BASE = 32'h0840_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ECC_W-1:0]  rsp_ecc,
    output logic              rsp_derr,
    output logic              ram_rd_en,
    output logic [IDX_W-1:0]  ram_rd_idx,
    input  logic [DATA_W-1:0] ram_rd_data,
    input  logic [ECC_W-1:0]  ram_rd_ecc
);
    localparam int WORD_BYTES = DATA_W / 8;

    win_e win_d;
    win_e win_q;
    logic valid_q;

    ecc_alias_decode #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .WORD_BYTES (WORD_BYTES),
        .DATA_BASE  (DATA_BASE),
        .CHECK_BASE (CHECK_BASE)
    ) u_decode (
        .addr (req_addr),
        .win  (win_d),
        .idx  (ram_rd_idx)
    );

    // Read the RAM only for addresses that hit a window.
    assign ram_rd_en = req_valid && (win_d != WIN_NONE);

    // Track the request and its window kind across the RAM latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            win_q   <= WIN_NONE;
        end else begin
            valid_q <= req_valid;
            win_q   <= req_valid ? win_d : WIN_NONE;
        end
    end

    ecc_alias_resp #(
        .DATA_W (DATA_W),
        .ECC_W  (ECC_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_q   (valid_q),
        .win_q     (win_q),
        .ram_data  (ram_rd_data),
        .ram_ecc   (ram_rd_ecc),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_ecc   (rsp_ecc),
        .rsp_derr  (rsp_derr)
    );

    // R7: a request is answered in the next cycle.
    p_req_answered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("request not answered");

    // R7: no response without a request.
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid)
        else $error("response without request");

    // R6: a request that skips the RAM comes back as a decode error.
    p_miss_derr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ram_rd_en) |=> rsp_derr)
        else $error("RAM skipped without decode error");

    // R8: a request that reads the RAM is not a decode error.
    p_hit_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |=> !rsp_derr)
        else $error("decode error on window hit");

endmodule

// File: tb/ecc_alias_rd_tb.sv
`timescale 1ns/1ps
module ecc_alias_rd_tb;

    localparam int IDX_W = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic [7:0]  rsp_ecc;
    logic        rsp_derr;
    logic        ram_rd_en;
    logic [IDX_W-1:0] ram_rd_idx;
    logic [63:0] ram_q_data = '0;
    logic [7:0]  ram_q_ecc = '0;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ecc_alias_rd u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_ecc     (rsp_ecc),
        .rsp_derr    (rsp_derr),
        .ram_rd_en   (ram_rd_en),
        .ram_rd_idx  (ram_rd_idx),
        .ram_rd_data (ram_q_data),
        .ram_rd_ecc  (ram_q_ecc)
    );

    // Contents of the RAM model as a function of the word index.
    function automatic logic [63:0] mdata(input int i);
        return {32'hD1A7_0000 | 32'(i), ~32'(i) ^ 32'h1234_5678};
    endfunction
    function automatic logic [7:0] mecc(input int i);
        return 8'(i * 37 + 11);
    endfunction

    // RAM model with one cycle of read latency.
    always @(posedge clk) begin
        if (ram_rd_en) begin
            ram_q_data <= mdata(int'(ram_rd_idx));
            ram_q_ecc  <= mecc(int'(ram_rd_idx));
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Kind: 0 neither window, 1 data window, 2 check window.
    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0800_0000, 2'd1},
        '{32'h0840_0000, 2'd2},
        '{32'h0800_0008, 2'd1},
        '{32'h0800_0015, 2'd1},
        '{32'h0840_0010, 2'd2},
        '{32'h0800_1FF8, 2'd1},
        '{32'h0800_2000, 2'd0},
        '{32'h0840_1FFF, 2'd2},
        '{32'h0840_2000, 2'd0},
        '{32'h07FF_FFF8, 2'd0},
        '{32'h0840_0ABC, 2'd2},
        '{32'h0000_0000, 2'd0},
        '{32'h0800_0ABC, 2'd1}
    };

    function automatic int vidx(input vec_t v);
        if (v.kind == 2'd1) return int'((v.addr - 32'h0800_0000) >> 3);
        if (v.kind == 2'd2) return int'((v.addr - 32'h0840_0000) >> 3);
        return 0;
    endfunction

    // Check the response of vector v, sampled one cycle after its request.
    task automatic chk_rsp(input vec_t v);
        int i = vidx(v);
        chk("R7 rsp_valid", 64'(rsp_valid), 64'd1);
        case (v.kind)
            2'd1: begin
                chk("R2 data", rsp_data, mdata(i));
                chk("R2 ecc", 64'(rsp_ecc), 64'(mecc(i)));
                chk("R8 derr", 64'(rsp_derr), 64'd0);
            end
            2'd2: begin
                chk("R4 lanes", rsp_data, {8{mecc(i)}});
                chk("R5 ecc", 64'(rsp_ecc), 64'(mecc(i)));
                chk("R8 derr", 64'(rsp_derr), 64'd0);
            end
            default: begin
                chk("R6 derr", 64'(rsp_derr), 64'd1);
                chk("R6 data", rsp_data, 64'd0);
                chk("R6 ecc", 64'(rsp_ecc), 64'd0);
            end
        endcase
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: a request during reset is not answered.
        req_valid = 1'b1;
        req_addr  = 32'h0800_0000;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 64'(rsp_valid), 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 64'(rsp_valid), 64'd0);

        // Walk the vectors back to back.
        for (int k = 0; k < NV; k++) begin
            if (k > 0) chk_rsp(VECS[k-1]);
            req_valid = 1'b1;
            req_addr  = VECS[k].addr;
            #1;
            if (VECS[k].kind == 2'd0) begin
                chk("R6 no RAM read", 64'(ram_rd_en), 64'd0);
            end else begin
                chk("R9 RAM enable", 64'(ram_rd_en), 64'd1);
                chk("R9 RAM index", 64'(ram_rd_idx), 64'(vidx(VECS[k])));
            end
            @(negedge clk);
        end
        chk_rsp(VECS[NV-1]);
        req_valid = 1'b0;

        // R7: idle cycles give no response.
        @(negedge clk);
        chk("R7 idle 1", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        chk("R7 idle 2", 64'(rsp_valid), 64'd0);

        // R7: a lone check-window request after a gap, answered once.
        req_valid = 1'b1;
        req_addr  = 32'h0840_0008;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 lone valid", 64'(rsp_valid), 64'd1);
        chk("R4 lone lanes", rsp_data, {8{mecc(1)}});
        @(negedge clk);
        chk("R7 single pulse", 64'(rsp_valid), 64'd0);

        // R1: reset taken together with a request suppresses its response.
        req_valid = 1'b1;
        req_addr  = 32'h0800_0010;
        rst_n     = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 reset wins", 64'(rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after re-reset", 64'(rsp_valid), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule